// File: doc/BRIEF.md
# Multi-Cycle Instruction Sequencer

This block is the control unit of a processor datapath that runs each instruction over several short clock steps and shares a single memory and a single ALU between them. It is a Moore state machine: every control strobe it drives depends only on the current step. The opcode is consulted only when the next step is chosen.

Every instruction begins with the same two steps, fetch and decode. After decode the sequencer branches by instruction class. Loads take five cycles. Stores and register-to-register operations take four. Conditional branches and jumps take three. Each class ends with a completion step that leads back to fetch. An opcode that matches no supported class goes from decode straight back to fetch.

Top module: `mc_sequencer`

## Requirements
- R1: A high `rst` sampled at a clock edge puts the sequencer in the fetch step. While `rst` stays high, the outputs keep the fetch pattern.
- R2: Fetch drives `mem_rd`=1, `instr_load`=1, `alu_b_sel`=01 and `pc_we`=1, with `pc_next_sel`=00, `alu_mode`=00, `alu_a_reg`=0 and `addr_sel_data`=0. The step after fetch is always decode.
- R3: Decode drives `alu_b_sel`=11 with `alu_a_reg`=0 and `alu_mode`=00. The next step is chosen from `opcode`: 100011 (load) or 101011 (store) go to address computation, 000000 (register op) goes to execute, 000100 (branch-if-equal) goes to branch completion, and 000010 (jump) goes to jump completion.
- R4: Address computation drives `alu_a_reg`=1 and `alu_b_sel`=10 with `alu_mode`=00. The next step is the load read for 100011 and store completion for 101011.
- R5: A load runs fetch, decode, address, read, write-back in 5 cycles. The read step drives `mem_rd`=1 and `addr_sel_data`=1. Write-back drives `reg_we`=1, `wb_from_mem`=1 and `dest_from_rd`=0.
- R6: A store runs in 4 cycles. Its completion step drives `mem_wr`=1 and `addr_sel_data`=1.
- R7: A register op runs in 4 cycles. Execute drives `alu_a_reg`=1, `alu_b_sel`=00 and `alu_mode`=10. Completion drives `reg_we`=1, `dest_from_rd`=1 and `wb_from_mem`=0.
- R8: A branch-if-equal runs in 3 cycles. Its completion step drives `alu_a_reg`=1, `alu_b_sel`=00, `alu_mode`=01, `pc_we_if_zero`=1 and `pc_next_sel`=01.
- R9: A jump runs in 3 cycles. Its completion step drives `pc_we`=1 and `pc_next_sel`=10.
- R10: Any opcode not listed in R3 returns from decode to fetch, so the instruction takes 2 cycles.
- R11: In every step, any strobe not named for that step is 0. `mem_rd` and `mem_wr` are never both high, and `pc_we` and `pc_we_if_zero` are never both high.
- R12: Changes to `opcode` in any step other than decode and address computation do not affect the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset to fetch |
| opcode | input | 6 | Opcode field of the held instruction |
| addr_sel_data | output | 1 | Memory address from the ALU result register (1) or from the PC (0) |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| instr_load | output | 1 | Load the instruction register |
| wb_from_mem | output | 1 | Register write data from memory data register (1) or ALU result (0) |
| dest_from_rd | output | 1 | Destination register from the rd field (1) or the rt field (0) |
| reg_we | output | 1 | Register file write enable |
| alu_a_reg | output | 1 | ALU first operand from register A (1) or the PC (0) |
| alu_b_sel | output | 2 | ALU second operand: 00 B, 01 constant 4, 10 offset, 11 offset times 4 |
| alu_mode | output | 2 | 00 add, 01 subtract, 10 function field decides |
| pc_we | output | 1 | Unconditional PC write |
| pc_we_if_zero | output | 1 | PC write when the ALU zero flag is set |
| pc_next_sel | output | 2 | PC source: 00 ALU output, 01 ALU result register, 10 jump target |

## Verification
All 64 opcode values are run from fetch while the opcode is held steady. The full output pattern is compared in every step, so a wrong dispatch, a wrong cycle count or a stray strobe in any class shows up. In a second pass the opcode changes to an unrelated value once the class has been fixed. This separates a sequencer that latches its decision from one that keeps watching the input. A reset in the middle of an instruction checks that the sequencer returns to fetch from a non-initial step.

// File: rtl/mc_sequencer.sv
module mc_sequencer (
  input  logic       clk,
  input  logic       rst,
  input  logic [5:0] opcode,
  output logic       addr_sel_data,
  output logic       mem_rd,
  output logic       mem_wr,
  output logic       instr_load,
  output logic       wb_from_mem,
  output logic       dest_from_rd,
  output logic       reg_we,
  output logic       alu_a_reg,
  output logic [1:0] alu_b_sel,
  output logic [1:0] alu_mode,
  output logic       pc_we,
  output logic       pc_we_if_zero,
  output logic [1:0] pc_next_sel
);
  localparam logic [5:0] OP_REG  = 6'b000000;
  localparam logic [5:0] OP_LOAD = 6'b100011;
  localparam logic [5:0] OP_STOR = 6'b101011;
  localparam logic [5:0] OP_BEQ  = 6'b000100;
  localparam logic [5:0] OP_JMP  = 6'b000010;

  typedef enum logic [3:0] {
    S_FETCH, S_DECODE, S_ADDR, S_RDMEM, S_LDWB,
    S_STORE, S_EXEC, S_REGWB, S_BRANCH, S_JUMP
  } step_t;

  step_t cur, nxt;

  always_ff @(posedge clk)
    if (rst) cur <= S_FETCH;
    else     cur <= nxt;

  always_comb begin
    nxt = S_FETCH;
    case (cur)
      S_FETCH:  nxt = S_DECODE;
      S_DECODE:
        case (opcode)
          OP_LOAD, OP_STOR: nxt = S_ADDR;
          OP_REG:           nxt = S_EXEC;
          OP_BEQ:           nxt = S_BRANCH;
          OP_JMP:           nxt = S_JUMP;
          default:          nxt = S_FETCH;
        endcase
      S_ADDR:   nxt = (opcode == OP_LOAD) ? S_RDMEM : S_STORE;
      S_RDMEM:  nxt = S_LDWB;
      S_EXEC:   nxt = S_REGWB;
      default:  nxt = S_FETCH;
    endcase
  end

  assign addr_sel_data = (cur == S_RDMEM) || (cur == S_STORE);
  assign mem_rd        = (cur == S_FETCH) || (cur == S_RDMEM);
  assign mem_wr        = (cur == S_STORE);
  assign instr_load    = (cur == S_FETCH);
  assign wb_from_mem   = (cur == S_LDWB);
  assign dest_from_rd  = (cur == S_REGWB);
  assign reg_we        = (cur == S_LDWB) || (cur == S_REGWB);
  assign alu_a_reg     = (cur == S_ADDR) || (cur == S_EXEC) || (cur == S_BRANCH);
  assign pc_we         = (cur == S_FETCH) || (cur == S_JUMP);
  assign pc_we_if_zero = (cur == S_BRANCH);

  always_comb begin
    alu_b_sel   = 2'b00;
    alu_mode    = 2'b00;
    pc_next_sel = 2'b00;
    case (cur)
      S_FETCH:  alu_b_sel = 2'b01;
      S_DECODE: alu_b_sel = 2'b11;
      S_ADDR:   alu_b_sel = 2'b10;
      S_EXEC:   alu_mode  = 2'b10;
      S_BRANCH: begin alu_mode = 2'b01; pc_next_sel = 2'b01; end
      S_JUMP:   pc_next_sel = 2'b10;
      default: ;
    endcase
  end
endmodule

module mc_sequencer_chk (
  input logic       clk,
  input logic       rst,
  input logic [5:0] opcode,
  input logic       addr_sel_data,
  input logic       mem_rd,
  input logic       mem_wr,
  input logic       instr_load,
  input logic       wb_from_mem,
  input logic       reg_we,
  input logic       alu_a_reg,
  input logic [1:0] alu_b_sel,
  input logic       pc_we,
  input logic       pc_we_if_zero
);
  // R1
  reset_to_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> instr_load);
  // R2
  fetch_then_decode_chk: assert property (@(posedge clk) disable iff (rst)
    instr_load |=> (alu_b_sel == 2'b11 && !instr_load));
  // R3
  load_dispatch_chk: assert property (@(posedge clk) disable iff (rst)
    (alu_b_sel == 2'b11 && opcode == 6'b100011) |=> (alu_a_reg && alu_b_sel == 2'b10));
  // R5
  read_then_wb_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && addr_sel_data) |=> (reg_we && wb_from_mem));
  // R6
  store_to_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    mem_wr |=> instr_load);
  // R7
  wb_to_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> instr_load);
  // R8
  branch_to_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    pc_we_if_zero |=> instr_load);
  // R11
  mem_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));
  // R11
  pc_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(pc_we && pc_we_if_zero));
endmodule

bind mc_sequencer mc_sequencer_chk u_chk (
  .clk(clk), .rst(rst), .opcode(opcode), .addr_sel_data(addr_sel_data),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .instr_load(instr_load),
  .wb_from_mem(wb_from_mem), .reg_we(reg_we), .alu_a_reg(alu_a_reg),
  .alu_b_sel(alu_b_sel), .pc_we(pc_we), .pc_we_if_zero(pc_we_if_zero)
);

// File: tb/test_mc_sequencer.sv
module test_mc_sequencer;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst = 1;
  logic [5:0] opcode = 6'b0;
  logic addr_sel_data, mem_rd, mem_wr, instr_load, wb_from_mem, dest_from_rd;
  logic reg_we, alu_a_reg, pc_we, pc_we_if_zero;
  logic [1:0] alu_b_sel, alu_mode, pc_next_sel;
  int checks = 0, fails = 0;
  logic done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mc_sequencer i_mc_sequencer (.*);

  // bench step codes: 0 fetch 1 decode 2 addr 3 read 4 ldwb 5 store 6 exec 7 regwb 8 branch 9 jump
  // bit order: addr_sel_data mem_rd mem_wr instr_load wb_from_mem dest_from_rd reg_we alu_a_reg b[2] mode[2] pc_we pc_if_zero src[2]
  function automatic logic [15:0] pat(int s);
    case (s)
      0: return 16'b0_1_0_1_0_0_0_0_01_00_1_0_00;
      1: return 16'b0_0_0_0_0_0_0_0_11_00_0_0_00;
      2: return 16'b0_0_0_0_0_0_0_1_10_00_0_0_00;
      3: return 16'b1_1_0_0_0_0_0_0_00_00_0_0_00;
      4: return 16'b0_0_0_0_1_0_1_0_00_00_0_0_00;
      5: return 16'b1_0_1_0_0_0_0_0_00_00_0_0_00;
      6: return 16'b0_0_0_0_0_0_0_1_00_10_0_0_00;
      7: return 16'b0_0_0_0_0_1_1_0_00_00_0_0_00;
      8: return 16'b0_0_0_0_0_0_0_1_00_01_0_1_01;
      default: return 16'b0_0_0_0_0_0_0_0_00_00_1_0_10;
    endcase
  endfunction

  function automatic logic [15:0] outs();
    return {addr_sel_data, mem_rd, mem_wr, instr_load, wb_from_mem, dest_from_rd,
            reg_we, alu_a_reg, alu_b_sel, alu_mode, pc_we, pc_we_if_zero, pc_next_sel};
  endfunction

  task automatic check(int s, string req);
    checks++;
    if (outs() !== pat(s)) begin
      fails++;
      $display("FAIL %s op=%b step=%0d actual=%b expected=%b", req, opcode, s, outs(), pat(s));
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  // run one instruction from fetch; if flip, opcode changes once class is fixed (R12)
  task automatic run(logic [5:0] op, bit flip);
    int path[3];
    int n;
    string req;
    n = 0;
    opcode = op;
    case (op)
      6'b100011: begin path[0]=2; path[1]=3; path[2]=4; n=3; req="R5"; end
      6'b101011: begin path[0]=2; path[1]=5; n=2; req="R6"; end
      6'b000000: begin path[0]=6; path[1]=7; n=2; req="R7"; end
      6'b000100: begin path[0]=8; n=1; req="R8"; end
      6'b000010: begin path[0]=9; n=1; req="R9"; end
      default:   req="R10";
    endcase
    if (flip) req = "R12";
    check(0, flip ? "R12" : "R2");
    step();
    check(1, flip ? "R12" : "R3");
    for (int k = 0; k < n; k++) begin
      step();
      if (flip && !(path[k] == 2)) opcode = op ^ 6'b101110;
      check(path[k], (path[k] == 2 && !flip) ? "R4" : req);
    end
    step();
    check(0, req);
  endtask

  initial begin
    step(); step();
    check(0, "R1");
    rst = 0;
    for (int o = 0; o < 64; o++) run(6'(o), 1'b0);
    run(6'b100011, 1'b1);
    run(6'b101011, 1'b1);
    run(6'b000000, 1'b1);
    run(6'b000100, 1'b1);
    run(6'b000010, 1'b1);
    // R11: strobes not named stay low across a mixed sequence
    run(6'b111111, 1'b0);
    // R1: reset mid-instruction
    opcode = 6'b100011;
    step(); step(); step();
    check(3, "R5");
    rst = 1;
    step();
    check(0, "R1");
    step();
    check(0, "R1");
    rst = 0;
    step();
    check(1, "R1");
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule